// File: doc/BRIEF.md
# I2C Byte Slave with Processor Registers

This block is a 7-bit-address I2C slave run by a local processor through four byte-wide registers. The processor programs the slave address, loads a byte to be sent, switches the slave on and then polls a status byte. When a bus master addresses the slave, it acknowledges. In a master-write transfer it captures the data byte and raises a sticky receive-done flag. In a master-read transfer it shifts out the loaded byte and raises a sticky send-done flag.

The control and status registers share one register address. A write there goes to control, and a read returns status. The sticky flags are cleared only by writing 1 to dedicated clear bits in the control byte. A soft-reset bit holds the bus engine and the flags at zero, and an enable bit decides whether the slave takes part on the bus at all. The bus pins are open-drain: the block can only pull SDA low or let it go.

Top module: `i2c_byte_slave`

## Requirements
- R1: Register 0 holds the slave address in bits 7:1, and bit 0 is ignored for matching. After a START, the slave compares bits 7:1 of the first byte with this address. On a match it pulls SDA low for the ninth clock. Bit 0 of that byte is 1 when the master reads and 0 when the master writes.
- R2: Register addresses are: 0 for the own address (read/write), 1 for control on write and status on read, 2 for the transmit byte (read/write), and 3 for the receive byte (read-only). All registers reset to 0.
- R3: While control bit 7 is 1, the bus engine and both sticky flags are held cleared. In this state status bits 4, 3 and 2 read 0 and no address is acknowledged.
- R4: Control bit 6 enables the slave and is mirrored in status bit 6. While it is 0, the slave never pulls SDA low.
- R5: At the end of each data byte written by the master, the slave acknowledges it, stores it in register 3 and sets status bit 3.
- R6: In a master-read transfer, the slave sends register 2 MSB first. Status bit 2 is set once the master has returned its acknowledge bit for that byte. After an ACK the byte is sent again; after a NACK the slave lets go of the bus.
- R7: Writing control bit 3 as 1 clears status bit 3, and writing control bit 2 as 1 clears status bit 2. Each clear acts only on its own flag. When a set and a clear of the same flag happen in the same cycle, the set wins.
- R8: Status bit 4 is 1 from a START until a STOP, an address mismatch or a NACK from the master ends the slave's part in the transfer.
- R9: Status bits 7, 5, 1 and 0 always read 0, and control bits 5:4 and 1:0 have no effect.
- R10: A repeated START at any point, including the middle of a data byte, restarts address detection. The partial byte is discarded and sets no flag.
- R11: SDA is only ever pulled low, and only during an acknowledge the slave owes or while it sends data. After a STOP the pull-down is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i (combinational) |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull_low_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The hardest situation to reach from the ports is a repeated START that arrives partway through a data byte. The slave must drop the half-collected bits, raise no receive flag and then answer a fresh address in the opposite direction. The bench's bus-master model gets there by sending an address, then four data bits, then a START while SCL is low, followed by a read-direction address. It then checks both the returned byte and the flag state. The same-cycle set/clear race of the sticky flags cannot be timed reliably through the synchroniser, so a property inside the register file covers it.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int BYTE_W  = 8;
    localparam int RADDR_W = 2;

    localparam logic [RADDR_W-1:0] RA_OWN  = 2'd0;
    localparam logic [RADDR_W-1:0] RA_CTRL = 2'd1;
    localparam logic [RADDR_W-1:0] RA_TX   = 2'd2;
    localparam logic [RADDR_W-1:0] RA_RX   = 2'd3;

    // control / status bit positions
    localparam int B_SRST   = 7;
    localparam int B_ACT    = 6;
    localparam int B_BUSY   = 4;
    localparam int B_RXFIN  = 3;
    localparam int B_TXFIN  = 2;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ADDR     = 3'd1,
        ST_ADDR_ACK = 3'd2,
        ST_RX       = 3'd3,
        ST_RX_ACK   = 3'd4,
        ST_TX       = 3'd5,
        ST_TX_ACK   = 3'd6,
        ST_WAIT     = 3'd7
    } bus_state_e;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl_ff;
        logic [STAGES-1:0] sda_ff;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;

    logic scl_s, sda_s;
    assign scl_s = q.scl_ff[STAGES-1];
    assign sda_s = q.sda_ff[STAGES-1];

    always_comb begin
        d          = q;
        d.scl_ff   = {q.scl_ff[STAGES-2:0], scl_i};
        d.sda_ff   = {q.sda_ff[STAGES-2:0], sda_i};
        d.scl_prev = scl_s;
        d.sda_prev = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign sda_o      = sda_s;
    assign scl_rise_o = scl_s & ~q.scl_prev;
    assign scl_fall_o = ~scl_s & q.scl_prev;
    assign start_o    = scl_s & q.scl_prev & q.sda_prev & ~sda_s;
    assign stop_o     = scl_s & q.scl_prev & ~q.sda_prev & sda_s;
endmodule

// File: rtl/i2cs_bit_engine.sv
module i2cs_bit_engine
    import i2cs_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_i,
    input  logic         sda_i,
    input  logic         scl_rise_i,
    input  logic         scl_fall_i,
    input  logic         start_i,
    input  logic         stop_i,
    input  logic [W-2:0] own_addr_i,
    input  logic [W-1:0] tx_byte_i,
    output logic [W-1:0] rx_byte_o,
    output logic         rx_done_o,
    output logic         tx_done_o,
    output logic         busy_o,
    output logic         sda_low_o
);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);

    typedef struct packed {
        bus_state_e     state;
        logic [W-1:0]   shreg;
        logic [CNT_W-1:0] cnt;
        logic           rw;
        logic           acked;
        logic           sda_low;
        logic           rx_done;
        logic           tx_done;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d         = q;
        d.rx_done = 1'b0;
        d.tx_done = 1'b0;
        if (hold_i) begin
            d = '0;
        end else if (stop_i) begin
            d.state   = ST_IDLE;
            d.sda_low = 1'b0;
        end else if (start_i) begin
            d.state   = ST_ADDR;
            d.cnt     = '0;
            d.sda_low = 1'b0;
        end else begin
            unique case (q.state)
                ST_ADDR: begin
                    if (scl_rise_i && q.cnt < CNT_FULL) begin
                        d.shreg = {q.shreg[W-2:0], sda_i};
                        d.cnt   = q.cnt + 1'b1;
                    end
                    if (scl_fall_i && q.cnt == CNT_FULL) begin
                        if (q.shreg[W-1:1] == own_addr_i) begin
                            d.state   = ST_ADDR_ACK;
                            d.sda_low = 1'b1;
                            d.rw      = q.shreg[0];
                        end else begin
                            d.state = ST_WAIT;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.state   = ST_TX;
                            d.shreg   = tx_byte_i;
                            d.sda_low = ~tx_byte_i[W-1];
                        end else begin
                            d.state   = ST_RX;
                            d.sda_low = 1'b0;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise_i && q.cnt < CNT_FULL) begin
                        d.shreg = {q.shreg[W-2:0], sda_i};
                        d.cnt   = q.cnt + 1'b1;
                    end
                    if (scl_fall_i && q.cnt == CNT_FULL) begin
                        d.state   = ST_RX_ACK;
                        d.sda_low = 1'b1;
                        d.rx_done = 1'b1;
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall_i) begin
                        d.state   = ST_RX;
                        d.sda_low = 1'b0;
                        d.cnt     = '0;
                    end
                end
                ST_TX: begin
                    if (scl_rise_i && q.cnt < CNT_FULL) begin
                        d.cnt = q.cnt + 1'b1;
                    end
                    if (scl_fall_i) begin
                        if (q.cnt == CNT_FULL) begin
                            d.state   = ST_TX_ACK;
                            d.sda_low = 1'b0;
                        end else if (q.cnt != '0) begin
                            d.shreg   = {q.shreg[W-2:0], 1'b0};
                            d.sda_low = ~q.shreg[W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise_i) begin
                        d.acked   = ~sda_i;
                        d.tx_done = 1'b1;
                    end
                    if (scl_fall_i) begin
                        if (q.acked) begin
                            d.state   = ST_TX;
                            d.shreg   = tx_byte_i;
                            d.sda_low = ~tx_byte_i[W-1];
                            d.cnt     = '0;
                        end else begin
                            d.state = ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_byte_o = q.shreg;
    assign rx_done_o = q.rx_done;
    assign tx_done_o = q.tx_done;
    assign sda_low_o = q.sda_low;
    assign busy_o    = (q.state != ST_IDLE) && (q.state != ST_WAIT);

    // R4
    held_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !sda_low_o);

    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !hold_i) |=> !busy_o);

    // R10
    restart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i && !hold_i) |=> (busy_o && !sda_low_o));
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile
    import i2cs_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int AW = RADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  rdata_o,
    input  logic          rx_done_i,
    input  logic          tx_done_i,
    input  logic [W-1:0]  rx_byte_i,
    input  logic          busy_i,
    output logic          hold_o,
    output logic [W-2:0]  own_addr_o,
    output logic [W-1:0]  tx_byte_o
);
    typedef struct packed {
        logic [W-1:0] own;
        logic [W-1:0] tx;
        logic [W-1:0] rx;
        logic         srst;
        logic         act;
        logic         rx_fin;
        logic         tx_fin;
    } regs_t;

    regs_t q, d;

    logic ctrl_wr, clr_rx, clr_tx;
    logic [W-1:0] status;

    assign ctrl_wr = wr_i && (addr_i == RA_CTRL);
    assign clr_rx  = ctrl_wr && wdata_i[B_RXFIN];
    assign clr_tx  = ctrl_wr && wdata_i[B_TXFIN];

    always_comb begin
        d = q;
        if (wr_i && addr_i == RA_OWN) d.own = wdata_i;
        if (wr_i && addr_i == RA_TX)  d.tx  = wdata_i;
        if (ctrl_wr) begin
            d.srst = wdata_i[B_SRST];
            d.act  = wdata_i[B_ACT];
        end
        if (rx_done_i) d.rx = rx_byte_i;
        if (q.srst) begin
            d.rx_fin = 1'b0;
            d.tx_fin = 1'b0;
        end else begin
            d.rx_fin = rx_done_i | (q.rx_fin & ~clr_rx);
            d.tx_fin = tx_done_i | (q.tx_fin & ~clr_tx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        status          = '0;
        status[B_ACT]   = q.act;
        status[B_BUSY]  = busy_i;
        status[B_RXFIN] = q.rx_fin;
        status[B_TXFIN] = q.tx_fin;
    end

    always_comb begin
        unique case (addr_i)
            RA_OWN:  rdata_o = q.own;
            RA_CTRL: rdata_o = status;
            RA_TX:   rdata_o = q.tx;
            default: rdata_o = q.rx;
        endcase
    end

    assign hold_o     = q.srst | ~q.act;
    assign own_addr_o = q.own[W-1:1];
    assign tx_byte_o  = q.tx;

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_i && clr_rx && !q.srst) |=> q.rx_fin);

    // R3
    srst_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.srst |=> (!q.rx_fin && !q.tx_fin));

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] == 1'b0) && (status[5] == 1'b0) && (status[1:0] == 2'b00));
endmodule

// File: rtl/i2c_byte_slave.sv
module i2c_byte_slave
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_i,
    input  logic [RADDR_W-1:0] reg_addr_i,
    input  logic [BYTE_W-1:0]  reg_wdata_i,
    output logic [BYTE_W-1:0]  reg_rdata_o,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_low_o
);
    logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic hold, rx_done, tx_done, busy;
    logic [BYTE_W-2:0] own_addr;
    logic [BYTE_W-1:0] tx_byte, rx_byte;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    i2cs_bit_engine #(.W(BYTE_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_i     (hold),
        .sda_i      (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_ev),
        .stop_i     (stop_ev),
        .own_addr_i (own_addr),
        .tx_byte_i  (tx_byte),
        .rx_byte_o  (rx_byte),
        .rx_done_o  (rx_done),
        .tx_done_o  (tx_done),
        .busy_o     (busy),
        .sda_low_o  (sda_pull_low_o)
    );

    i2cs_regfile #(.W(BYTE_W), .AW(RADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .rx_done_i  (rx_done),
        .tx_done_i  (tx_done),
        .rx_byte_i  (rx_byte),
        .busy_i     (busy),
        .hold_o     (hold),
        .own_addr_o (own_addr),
        .tx_byte_o  (tx_byte)
    );
endmodule

// File: tb/i2c_byte_slave_tb.sv
module i2c_byte_slave_tb;
    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       mscl = 1'b1;
    logic       msda = 1'b1;
    logic       sda_low;
    logic       sda_line;

    int checks = 0;
    int errors = 0;

    assign sda_line = msda & ~sda_low;

    always #2.5 clk = ~clk;

    i2c_byte_slave u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr_i       (reg_wr),
        .reg_addr_i     (reg_addr),
        .reg_wdata_i    (reg_wdata),
        .reg_rdata_o    (reg_rdata),
        .scl_i          (mscl),
        .sda_i          (sda_line),
        .sda_pull_low_o (sda_low)
    );

    // {rw, addr[6:0], data[7:0], expected address ack}
    localparam logic [16:0] VEC [5] = '{
        {1'b0, 7'h42, 8'hA5, 1'b1},
        {1'b1, 7'h42, 8'h5A, 1'b1},
        {1'b0, 7'h11, 8'h77, 1'b0},
        {1'b1, 7'h43, 8'h66, 1'b0},
        {1'b0, 7'h42, 8'h00, 1'b1}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        wclk(2);
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic bus_start();
        mscl = 1'b0; wclk(H);
        msda = 1'b1; wclk(H);
        mscl = 1'b1; wclk(H);
        msda = 1'b0; wclk(H);
        mscl = 1'b0; wclk(H);
    endtask

    task automatic bus_stop();
        mscl = 1'b0; msda = 1'b0; wclk(H);
        mscl = 1'b1; wclk(H);
        msda = 1'b1; wclk(H);
    endtask

    task automatic put_bit(input logic b);
        msda = b; wclk(H);
        mscl = 1'b1; wclk(H);
        mscl = 1'b0; wclk(2);
    endtask

    task automatic get_bit(output logic b);
        msda = 1'b1; wclk(H);
        mscl = 1'b1; wclk(H/2);
        b = sda_line; wclk(H/2);
        mscl = 1'b0; wclk(2);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic get_byte(input logic ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~ack);
    endtask

    task automatic write_xfer(input logic [6:0] a, input logic [7:0] v, output logic ack);
        logic dack;
        bus_start();
        put_byte({a, 1'b0}, ack);
        if (ack) put_byte(v, dack);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic ack, dack;
        logic [7:0] last_rx;

        wclk(5);
        // reset state
        reg_read(2'd1, v); chk("R9 status after reset", v, 8'h00);
        reg_read(2'd0, v); chk("R2 own address after reset", v, 8'h00);
        chk("R11 no pull-down in reset", {7'd0, sda_low}, 8'h00);
        rst_n = 1'b1;
        wclk(3);

        reg_write(2'd0, 8'h84);
        reg_write(2'd1, 8'h40);
        reg_read(2'd1, v); chk("R4 enable mirrored", v, 8'h40);
        reg_write(2'd2, 8'h3C);
        reg_read(2'd2, v); chk("R2 tx register readback", v, 8'h3C);
        last_rx = 8'h00;

        // table of transfers
        foreach (VEC[k]) begin
            logic rw; logic [6:0] a; logic [7:0] dat; logic eack;
            {rw, a, dat, eack} = VEC[k];
            if (rw) reg_write(2'd2, dat);
            bus_start();
            put_byte({a, rw}, ack);
            chk("R1 address acknowledge", {7'd0, ack}, {7'd0, eack});
            if (ack && !rw) begin
                put_byte(dat, dack);
                chk("R5 data acknowledge", {7'd0, dack}, 8'h01);
                bus_stop();
                last_rx = dat;
                reg_read(2'd1, v); chk("R5 receive flag", v, 8'h48);
            end else if (ack && rw) begin
                get_byte(1'b0, v);
                chk("R6 byte sent", v, dat);
                bus_stop();
                reg_read(2'd1, v); chk("R6 send flag", v, 8'h44);
            end else begin
                bus_stop();
                reg_read(2'd1, v); chk("R1 no flag on mismatch", v, 8'h40);
            end
            chk("R11 released after stop", {7'd0, sda_low}, 8'h00);
            reg_read(2'd3, v); chk("R5 receive register", v, last_rx);
            reg_write(2'd1, 8'h4C);
            reg_read(2'd1, v); chk("R7 flags cleared", v, 8'h40);
        end

        // R7: clears act on their own flag only
        write_xfer(7'h42, 8'h11, ack);
        reg_write(2'd2, 8'h22);
        bus_start(); put_byte({7'h42, 1'b1}, ack); get_byte(1'b0, v); bus_stop();
        reg_read(2'd1, v); chk("R7 both flags set", v, 8'h4C);
        reg_write(2'd1, 8'h44);
        reg_read(2'd1, v); chk("R7 send clear only", v, 8'h48);
        reg_write(2'd1, 8'h48);
        reg_read(2'd1, v); chk("R7 receive clear", v, 8'h40);

        // R6: master ACK makes the byte go out again
        reg_write(2'd2, 8'h96);
        bus_start(); put_byte({7'h42, 1'b1}, ack);
        get_byte(1'b1, v); chk("R6 first byte", v, 8'h96);
        get_byte(1'b0, v); chk("R6 repeated byte after ACK", v, 8'h96);
        bus_stop();
        reg_write(2'd1, 8'h4C);

        // R8: busy during transfer
        bus_start(); put_byte({7'h42, 1'b0}, ack);
        reg_read(2'd1, v); chk("R8 busy while addressed", v, 8'h50);
        put_byte(8'h3E, dack);
        bus_stop();
        reg_read(2'd1, v); chk("R8 busy cleared by stop", v, 8'h48);
        reg_write(2'd1, 8'h4C);
        bus_start(); put_byte({7'h13, 1'b0}, ack);
        reg_read(2'd1, v); chk("R8 busy cleared on mismatch", v, 8'h40);
        bus_stop();

        // R10: repeated start in the middle of a byte
        reg_write(2'd2, 8'hC3);
        bus_start(); put_byte({7'h42, 1'b0}, ack);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_start(); put_byte({7'h42, 1'b1}, ack);
        chk("R10 address after restart", {7'd0, ack}, 8'h01);
        get_byte(1'b0, v); chk("R10 byte after restart", v, 8'hC3);
        bus_stop();
        reg_read(2'd1, v); chk("R10 partial byte sets no flag", v, 8'h44);
        reg_read(2'd3, v); chk("R10 receive register kept", v, 8'h3E);
        reg_write(2'd1, 8'h4C);

        // R1: bit 0 of own address ignored
        reg_write(2'd0, 8'h85);
        write_xfer(7'h42, 8'h99, ack);
        chk("R1 own address bit 0 ignored", {7'd0, ack}, 8'h01);
        reg_read(2'd3, v); chk("R1 data after odd own address", v, 8'h99);
        reg_write(2'd0, 8'h84);
        reg_write(2'd1, 8'h4C);

        // R4: disabled slave
        reg_write(2'd1, 8'h00);
        reg_read(2'd1, v); chk("R4 disabled status", v, 8'h00);
        write_xfer(7'h42, 8'h12, ack);
        chk("R4 no ack while disabled", {7'd0, ack}, 8'h00);
        reg_read(2'd3, v); chk("R4 receive register untouched", v, 8'h99);
        reg_write(2'd1, 8'h40);

        // R3: soft reset
        write_xfer(7'h42, 8'h5C, ack);
        reg_read(2'd1, v); chk("R3 flag before soft reset", v, 8'h48);
        reg_write(2'd1, 8'hC0);
        reg_read(2'd1, v); chk("R3 flags held clear", v, 8'h40);
        write_xfer(7'h42, 8'h01, ack);
        chk("R3 no ack in soft reset", {7'd0, ack}, 8'h00);
        reg_write(2'd1, 8'h40);
        write_xfer(7'h42, 8'h02, ack);
        chk("R3 ack after release", {7'd0, ack}, 8'h01);
        reg_write(2'd1, 8'h4C);

        // R9: reserved control bits, reserved status bits
        reg_write(2'd1, 8'h73);
        reg_read(2'd1, v); chk("R9 reserved bits zero", v, 8'h40);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule